// File: doc/BRIEF.md
# Bus Address Selector Tile with Wait Generation

This block is one selector tile on a pipelined, distributed system bus. It watches every bus access, decides whether the access falls inside the window of user registers it owns, and if so presents a select, the write data and the local offset to the user logic behind it. It returns read data by driving its share of a wired-OR read line: the tile drives all zeros except in the single cycle that carries its answer.

The decode window is not fixed in silicon. A base address, a don't-care mask and a wait-enable flag are loaded once through a configuration port during start-up. The load also marks the tile as configured. Until then the tile answers nothing, and after it further loads are refused until reset. With waits enabled, every hit stalls the bus for one cycle without help from the user logic. Slow or handshaking user logic keeps the stall going for as long as it holds its extend request.

Top module: `bus_select_tile`

## Requirements
- R1: After a synchronous reset, usr_sel, usr_wr, bus_wait and bus_rdata are all zero and the tile is unconfigured.
- R2: While the tile is unconfigured, no bus access produces a select, a wait or read data.
- R3: The first cfg_load pulse after reset captures cfg_base, cfg_mask and cfg_wait_en and marks the tile configured. Every later cfg_load is ignored until the next reset.
- R4: An access with bus_req high hits when every address bit whose cfg_mask bit is 0 equals the same bit of the base. A hit raises usr_sel in the next cycle, with usr_addr equal to bus_addr AND mask. A miss changes nothing.
- R5: With waits enabled, bus_wait rises together with usr_sel on every hit, giving at least one wait cycle with no user involvement.
- R6: With waits enabled, each cycle in which usr_hold is high while usr_sel is high keeps usr_sel and bus_wait high for one more cycle. The total is 1 plus the number of consecutive hold cycles.
- R7: With waits disabled, bus_wait never rises, usr_sel lasts exactly one cycle, and usr_hold has no effect.
- R8: For a write hit, usr_wr is high and usr_wdata equals the bus write data for as long as usr_sel is high. usr_wr is never high without usr_sel.
- R9: For a read hit, bus_rdata equals usr_rdata sampled in the last selected cycle, for exactly the one cycle after usr_sel falls. In every other cycle, including write hits and misses, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-shot configuration load strobe |
| cfg_base | input | ADDR_W | Base address to decode |
| cfg_mask | input | ADDR_W | Don't-care bits of the address compare (1 = ignore) |
| cfg_wait_en | input | 1 | Enable automatic wait generation |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data line |
| bus_rdata | output | DATA_W | This tile's contribution to the wired-OR read line |
| bus_wait | output | 1 | Stall request to the bus pipeline |
| usr_sel | output | 1 | Select to the user register group |
| usr_wr | output | 1 | Write qualifier to user logic |
| usr_addr | output | ADDR_W | Offset inside the window (address AND mask) |
| usr_wdata | output | DATA_W | Write data to user logic |
| usr_rdata | input | DATA_W | Read data from user logic |
| usr_hold | input | 1 | User request to extend the wait |

## Verification
A corrupted base or mask shows up in the cycle after the next access as a missing or extra usr_sel. A stuck busy state leaves usr_sel and bus_wait high one cycle longer than the hold pattern allows. A read register that leaks data puts a nonzero value on bus_rdata in a cycle other than the one right after usr_sel falls. All of these are caught because every output is compared against a behavioural model on every clock, from the first cycle after reset.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_BUSY = 1'b1
  } sel_state_e;

  function automatic logic addr_bit_ok(input logic a, input logic b, input logic dc);
    return dc | ~(a ^ b);
  endfunction
endpackage

// File: rtl/sel_cfg.sv
module sel_cfg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_wait_en,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic              wait_en_q,
  output logic              valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mask_q    <= '0;
      wait_en_q <= 1'b0;
      valid_q   <= 1'b0;
    end else if (cfg_load && !valid_q) begin
      base_q    <= cfg_base;
      mask_q    <= cfg_mask;
      wait_en_q <= cfg_wait_en;
      valid_q   <= 1'b1;
    end
  end

  // R3: configuration frozen once valid
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q)) |-> ($stable(base_q) && $stable(mask_q) && $stable(wait_en_q)));
endmodule

// File: rtl/sel_match.sv
module sel_match import sel_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = addr_bit_ok(addr[i], base[i], mask[i]);
  end

  assign hit = valid & req & (&bit_ok);
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl import sel_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic bus_wr,
  input  logic wait_en,
  input  logic usr_hold,
  output logic start,
  output logic done,
  output logic sel_q,
  output logic wr_q,
  output logic wait_q
);
  sel_state_e state;

  always_comb begin
    start = (state == SEL_IDLE) && hit;
    done  = (state == SEL_BUSY) && !(wait_en && usr_hold);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEL_IDLE;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      wait_q <= 1'b0;
    end else if (start) begin
      state  <= SEL_BUSY;
      sel_q  <= 1'b1;
      wr_q   <= bus_wr;
      wait_q <= wait_en;
    end else if (done) begin
      state  <= SEL_IDLE;
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      wait_q <= 1'b0;
    end
  end

  // R5: first wait comes with the select
  assert_auto_wait_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sel_q) && wait_en) |-> wait_q);
  // R6: hold keeps the access stalled
  assert_hold_extends_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_q && wait_q && usr_hold) |=> (sel_q && wait_q));
  // R7: no wait and single-cycle select when disabled
  assert_no_wait_R7: assert property (@(posedge clk) disable iff (rst)
    !wait_en |-> !wait_q);
  assert_single_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (!wait_en && sel_q) |=> !sel_q);
endmodule

// File: rtl/sel_data.sv
module sel_data #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              done,
  input  logic              wr_q,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] usr_rdata,
  output logic [ADDR_W-1:0] uaddr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr_q <= '0;
      wdata_q <= '0;
    end else if (start) begin
      uaddr_q <= bus_addr & mask;
      wdata_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= (done && !wr_q) ? usr_rdata : '0;
  end
endmodule

// File: rtl/bus_select_tile.sv
module bus_select_tile #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              cfg_wait_en,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              usr_sel,
  output logic              usr_wr,
  output logic [ADDR_W-1:0] usr_addr,
  output logic [DATA_W-1:0] usr_wdata,
  input  logic [DATA_W-1:0] usr_rdata,
  input  logic              usr_hold
);
  logic [ADDR_W-1:0] base_q, mask_q;
  logic wait_en_q, valid_q, hit, start, done;

  sel_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_wait_en(cfg_wait_en), .base_q(base_q),
    .mask_q(mask_q), .wait_en_q(wait_en_q), .valid_q(valid_q)
  );

  sel_match #(.ADDR_W(ADDR_W)) u_match (
    .valid(valid_q), .req(bus_req), .addr(bus_addr), .base(base_q),
    .mask(mask_q), .hit(hit)
  );

  sel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hit(hit), .bus_wr(bus_wr), .wait_en(wait_en_q),
    .usr_hold(usr_hold), .start(start), .done(done), .sel_q(usr_sel),
    .wr_q(usr_wr), .wait_q(bus_wait)
  );

  sel_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .start(start), .done(done), .wr_q(usr_wr),
    .bus_addr(bus_addr), .mask(mask_q), .bus_wdata(bus_wdata),
    .usr_rdata(usr_rdata), .uaddr_q(usr_addr), .wdata_q(usr_wdata),
    .rdata_q(bus_rdata)
  );

  // R2: nothing is selected before configuration
  assert_no_sel_unconfigured_R2: assert property (@(posedge clk) disable iff (rst)
    usr_sel |-> valid_q);
  // R8: write qualifier only inside a select
  assert_wr_inside_sel_R8: assert property (@(posedge clk) disable iff (rst)
    usr_wr |-> usr_sel);
  // R9: read line is zero except right after a read select ends
  assert_rd_after_sel_R9: assert property (@(posedge clk) disable iff (rst)
    (|bus_rdata) |-> ($fell(usr_sel) && !$past(usr_wr)));
endmodule

// File: tb/bus_select_tile_bench.sv
`timescale 1ns/1ps
module bus_select_tile_bench;
  localparam int AW = 16;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0, cfg_wait_en = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_wait, usr_sel, usr_wr;
  logic [AW-1:0] usr_addr;
  logic [DW-1:0] usr_wdata;
  logic [DW-1:0] usr_rdata = '0;
  logic usr_hold = 1'b0;

  int errors = 0;
  int checks = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  bus_select_tile #(.ADDR_W(AW), .DATA_W(DW)) u_bus_select_tile (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_wait_en(cfg_wait_en), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait), .usr_sel(usr_sel),
    .usr_wr(usr_wr), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
    .usr_rdata(usr_rdata), .usr_hold(usr_hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_valid, m_wen, m_sel, m_wr, m_wait;
  int m_base, m_mask, m_uaddr, m_wdata, m_rd;

  always @(posedge clk) begin
    bit hit;
    if (rst) begin
      m_valid = 0; m_wen = 0; m_sel = 0; m_wr = 0; m_wait = 0;
      m_base = 0; m_mask = 0; m_uaddr = 0; m_wdata = 0; m_rd = 0;
    end else begin
      hit = m_valid && bus_req && ((((int'(bus_addr)) ^ m_base) & ~m_mask & 32'hFFFF) == 0);
      m_rd = 0;
      if (!m_sel) begin
        if (hit) begin
          m_sel = 1; m_wr = bus_wr; m_wait = m_wen;
          m_uaddr = int'(bus_addr) & m_mask; m_wdata = int'(bus_wdata);
        end
      end else if (!(m_wen && usr_hold)) begin
        if (!m_wr) m_rd = int'(usr_rdata);
        m_sel = 0; m_wr = 0; m_wait = 0;
      end
      if (cfg_load && !m_valid) begin
        m_valid = 1; m_base = int'(cfg_base); m_mask = int'(cfg_mask); m_wen = cfg_wait_en;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R4 usr_sel (model)", int'(usr_sel), int'(m_sel));
      chk("R5/R6/R7 bus_wait (model)", int'(bus_wait), int'(m_wait));
      chk("R8 usr_wr (model)", int'(usr_wr), int'(m_wr));
      chk("R9 bus_rdata (model)", int'(bus_rdata), m_rd);
      if (m_sel) begin
        chk("R4 usr_addr (model)", int'(usr_addr), m_uaddr);
        chk("R8 usr_wdata (model)", int'(usr_wdata), m_wdata);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic configure(input int base, input int mask, input bit wen);
    @(negedge clk);
    cfg_load = 1; cfg_base = AW'(base); cfg_mask = AW'(mask); cfg_wait_en = wen;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // one access; counts wait cycles and ORs the read line over the window
  task automatic access(input string tag, input int addr, input bit wr, input int wd,
                        input int rdv, input int hold, input bit exp_hit,
                        input int exp_waits, input int exp_rd);
    int waits = 0;
    int rdacc = 0;
    @(negedge clk);
    bus_req = 1; bus_addr = AW'(addr); bus_wr = wr; bus_wdata = DW'(wd);
    usr_rdata = DW'(rdv);
    @(negedge clk);
    bus_req = 0;
    chk({tag, " R4 select"}, int'(usr_sel), int'(exp_hit));
    if (exp_hit) begin
      chk({tag, " R8 usr_wr"}, int'(usr_wr), int'(wr));
      if (wr) chk({tag, " R8 usr_wdata"}, int'(usr_wdata), wd);
    end
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      usr_hold = (k < hold);
      waits += int'(bus_wait);
      rdacc |= int'(bus_rdata);
    end
    usr_hold = 0;
    chk({tag, " R5/R6/R7 wait cycles"}, waits, exp_waits);
    chk({tag, " R9 read value"}, rdacc, exp_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    model_on = 1;
    // R1: reset state
    chk("R1 usr_sel reset", int'(usr_sel), 0);
    chk("R1 bus_wait reset", int'(bus_wait), 0);
    chk("R1 bus_rdata reset", int'(bus_rdata), 0);
    // R2: unconfigured tile ignores accesses
    access("unconfigured", 'h1235, 0, 0, 'h9, 0, 0, 0, 0);
    configure('h1230, 'h000F, 1);
    // R4/R5/R9: read hit, single automatic wait
    @(negedge clk);
    bus_req = 1; bus_addr = 16'h1235; bus_wr = 0; usr_rdata = 4'hA;
    @(negedge clk);
    bus_req = 0;
    chk("R4 usr_addr offset", int'(usr_addr), 'h5);
    repeat (4) @(negedge clk);
    access("read h0", 'h1236, 0, 0, 'hA, 0, 1, 1, 'hA);
    // R6: held three cycles
    access("read h3", 'h1231, 0, 0, 'h5, 3, 1, 4, 'h5);
    // R8/R9: write hit returns zero on the read line
    access("write", 'h123F, 1, 'h6, 'hF, 1, 1, 2, 0);
    // R4: miss just outside the window
    access("miss", 'h1240, 0, 0, 'hF, 0, 0, 0, 0);
    // R3: second load refused
    configure('h5550, 'h0000, 0);
    access("reload new base", 'h5550, 0, 0, 'h3, 0, 0, 0, 0);
    access("reload old base", 'h1230, 0, 0, 'h3, 0, 1, 1, 'h3);
    // R7: waits disabled, exact match
    do_reset();
    chk("R1 after reset sel", int'(usr_sel), 0);
    access("R2 after reset", 'h1230, 0, 0, 'h7, 0, 0, 0, 0);
    configure('h00C3, 'h0000, 0);
    access("nowait hold", 'h00C3, 0, 0, 'hC, 2, 1, 0, 'hC);
    access("nowait write", 'h00C3, 1, 'h9, 'hC, 0, 1, 0, 0);
    access("exact miss", 'h00C4, 0, 0, 'hC, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule